// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This block is a 64-bit fixed-point arithmetic and logic unit whose datapath can be split into independent lanes. A 2-bit lane-size select makes one operation run as eight 8-bit, four 16-bit, two 32-bit or one 64-bit computation. The adder chain is cut at every lane boundary, so no carry or borrow passes from one lane into the next. A 3-bit opcode selects wrapping add, wrapping subtract, signed saturating add, bitwise AND, OR, XOR, or pass-through of operand A. Each lane reports its own carry-out and signed overflow.

Operations enter on a valid/ready input channel and leave on a valid/ready output channel through one register stage. The input is ready whenever the output register is empty or is being drained in the same cycle. A result therefore appears one cycle after it is accepted, and a new operation can enter every cycle while the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the output holds its value and no new operation is taken.

Top module: `simd_alu`

## Requirements
- R1: Lane size `in_lane` is encoded 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Opcode 0 (add) gives each lane (A + B) modulo 2^w, where w is the lane width, and no carry reaches the next lane.
- R2: Opcode 1 (subtract) gives each lane (A - B) modulo 2^w. The lane's carry flag is the carry-out of A + ~B + 1, so it is 1 exactly when no borrow occurs (A >= B unsigned).
- R3: Opcode 2 (saturating add) treats each lane as signed. On overflow it clamps the lane to 2^(w-1)-1 when A is non-negative and to -2^(w-1) when A is negative. The overflow flag marks every clamped lane.
- R4: For opcodes 0, 1 and 2, a lane's carry flag and overflow flag sit at bit index (top byte index of that lane) of `out_carry` and `out_ovf`. All other flag bits are 0, so in 64-bit mode only bit 7 can be set.
- R5: Opcodes 3 (AND), 4 (OR) and 5 (XOR) give the same 64-bit bitwise result in every lane mode, and both flag vectors are 0.
- R6: Opcodes 6 and 7 pass operand A to the result unchanged, with both flag vectors 0.
- R7: `in_ready` equals `!out_valid || out_ready`. An operation is accepted at a rising edge where `in_valid` and `in_ready` are both high, and its result is presented with `out_valid` high from that edge on.
- R8: While `out_valid` is high and `out_ready` is low, the result and flags stay unchanged and the input offered is not accepted.
- R9: With `out_ready` held high, one operation is accepted every cycle and results come out in order, one per cycle.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 saturating add, 3 AND, 4 OR, 5 XOR, 6/7 pass A) |
| in_lane | input | 2 | Lane size select |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Lane-wise result |
| out_carry | output | 8 | Carry-out flag per lane, at the lane's top byte index |
| out_ovf | output | 8 | Signed overflow flag per lane, at the lane's top byte index |

## Verification
The hardest case to reach from the ports is a carry or borrow that would cross a lane boundary. Only operands whose low lane runs all ones, or whose lane tops meet in a boundary pattern, expose a missing cut. The stimulus therefore pairs random operands with boundary patterns for every opcode in every lane mode: all ones plus one, 0x7F/0x80 repeated per lane, and zero minus one. The same operand pairs are run under all four lane sizes, so that a chain cut at the wrong byte shows up as a wrong neighbouring lane.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_ADDS  = 3'd2,
    OP_AND   = 3'd3,
    OP_OR    = 3'd4,
    OP_XOR   = 3'd5,
    OP_PASS  = 3'd6,
    OP_PASSB = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sel_e;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDS);
  endfunction

  function automatic logic op_is_logic(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/simd_lane_cut.sv
// Marks the bytes that are the top byte of a lane for the selected lane size.
module simd_lane_cut #(
  parameter int NBYTES = 8
) (
  input  logic [1:0]        lane,
  output logic [NBYTES-1:0] cut
);
  always_comb begin
    for (int i = 0; i < NBYTES; i++) begin
      cut[i] = ((unsigned'(i + 1) & ((32'd1 << lane) - 32'd1)) == 32'd0);
    end
  end
endmodule

// File: rtl/simd_seg_adder.sv
// Byte-sliced adder whose carry chain restarts at every lane boundary.
module simd_seg_adder #(
  parameter int NBYTES = 8,
  localparam int DW = 8 * NBYTES
) (
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic              sub,
  input  logic [NBYTES-1:0] cut,
  output logic [DW-1:0]     sum,
  output logic [NBYTES-1:0] cout,
  output logic [NBYTES-1:0] ovf
);
  logic [DW-1:0] b_eff;
  assign b_eff = sub ? ~b : b;

  genvar i;
  generate
    for (i = 0; i < NBYTES; i++) begin : g_byte
      logic       cin;
      logic [8:0] part;
      if (i == 0) begin : g_first
        assign cin = sub;
      end else begin : g_rest
        assign cin = cut[i-1] ? sub : cout[i-1];
      end
      assign part = {1'b0, a[8*i +: 8]} + {1'b0, b_eff[8*i +: 8]} + {8'd0, cin};
      assign sum[8*i +: 8] = part[7:0];
      assign cout[i]       = part[8];
      assign ovf[i]        = (a[8*i+7] == b_eff[8*i+7]) && (part[7] != a[8*i+7]);
    end
  endgenerate
endmodule

// File: rtl/simd_sat_clamp.sv
// Replaces overflowed lanes with the signed extreme matching operand A's sign.
module simd_sat_clamp #(
  parameter int NBYTES = 8,
  localparam int DW = 8 * NBYTES
) (
  input  logic [DW-1:0]     sum,
  input  logic [DW-1:0]     a,
  input  logic [NBYTES-1:0] ovf,
  input  logic [NBYTES-1:0] cut,
  output logic [DW-1:0]     sat
);
  logic [NBYTES-1:0] lane_ovf;
  logic [NBYTES-1:0] lane_neg;

  always_comb begin
    logic cur_ovf;
    logic cur_neg;
    cur_ovf = 1'b0;
    cur_neg = 1'b0;
    for (int j = NBYTES - 1; j >= 0; j--) begin
      if (cut[j]) begin
        cur_ovf = ovf[j];
        cur_neg = a[8*j+7];
      end
      lane_ovf[j] = cur_ovf;
      lane_neg[j] = cur_neg;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NBYTES; k++) begin : g_clamp
      logic [7:0] clamp_byte;
      always_comb begin
        if (cut[k]) clamp_byte = lane_neg[k] ? 8'h80 : 8'h7F;
        else        clamp_byte = lane_neg[k] ? 8'h00 : 8'hFF;
      end
      assign sat[8*k +: 8] = lane_ovf[k] ? clamp_byte : sum[8*k +: 8];
    end
  endgenerate
endmodule

// File: rtl/simd_logic_unit.sv
// Bitwise operations; independent of lane size.
module simd_logic_unit
  import simd_alu_pkg::*;
#(
  parameter int DW = 64
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int DW = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_lane,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_result,
  output logic [NBYTES-1:0] out_carry,
  output logic [NBYTES-1:0] out_ovf
);
  alu_op_e           op;
  logic [NBYTES-1:0] cut;
  logic [DW-1:0]     sum;
  logic [DW-1:0]     sat;
  logic [DW-1:0]     lgc;
  logic [NBYTES-1:0] byte_cy;
  logic [NBYTES-1:0] byte_ov;
  logic [DW-1:0]     nxt_result;
  logic [NBYTES-1:0] nxt_carry;
  logic [NBYTES-1:0] nxt_ovf;
  logic              accept;

  assign op = alu_op_e'(in_op);

  simd_lane_cut #(.NBYTES(NBYTES)) cut_i (
    .lane (in_lane),
    .cut  (cut)
  );

  simd_seg_adder #(.NBYTES(NBYTES)) add_i (
    .a    (in_a),
    .b    (in_b),
    .sub  (op == OP_SUB),
    .cut  (cut),
    .sum  (sum),
    .cout (byte_cy),
    .ovf  (byte_ov)
  );

  simd_sat_clamp #(.NBYTES(NBYTES)) sat_i (
    .sum (sum),
    .a   (in_a),
    .ovf (byte_ov),
    .cut (cut),
    .sat (sat)
  );

  simd_logic_unit #(.DW(DW)) lgc_i (
    .op (op),
    .a  (in_a),
    .b  (in_b),
    .y  (lgc)
  );

  always_comb begin
    if (op == OP_ADDS)      nxt_result = sat;
    else if (op_is_arith(op)) nxt_result = sum;
    else                    nxt_result = lgc;
    nxt_carry = op_is_arith(op) ? (byte_cy & cut) : '0;
    nxt_ovf   = op_is_arith(op) ? (byte_ov & cut) : '0;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= '0;
      out_ovf    <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= nxt_result;
        out_carry  <= nxt_carry;
        out_ovf    <= nxt_ovf;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int NBYTES = 8,
  localparam int DW = 8 * NBYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [1:0]        in_lane,
  input logic [DW-1:0]     in_a,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DW-1:0]     out_result,
  input logic [NBYTES-1:0] out_carry,
  input logic [NBYTES-1:0] out_ovf
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R7
  p_ready_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_accept_gives_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R8
  p_hold_under_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_carry) && $stable(out_ovf)));
  p_no_take_under_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R5
  p_logic_no_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 3'd3 || in_op == 3'd4 || in_op == 3'd5))
      |=> (out_carry == '0 && out_ovf == '0));
  // R6
  p_pass_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[2:1] == 2'b11) |=> (out_result == $past(in_a) && out_carry == '0));
  // R4
  p_wide_top_flag_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_lane == 2'd3)
      |=> (out_carry[NBYTES-2:0] == '0 && out_ovf[NBYTES-2:0] == '0));
endmodule

bind simd_alu simd_alu_chk #(.NBYTES(NBYTES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_lane    (in_lane),
  .in_a       (in_a),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_carry  (out_carry),
  .out_ovf    (out_ovf)
);

// File: tb/simd_alu_tb_top.sv
`timescale 1ns/1ps
module simd_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [1:0]  in_lane = 2'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [7:0]  out_carry;
  logic [7:0]  out_ovf;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  simd_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_lane(in_lane), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_carry(out_carry), .out_ovf(out_ovf)
  );

  // Lane-by-lane reference model built from the requirements.
  task automatic ref_alu(input logic [2:0] op, input logic [1:0] lm,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic [7:0] cf,
                         output logic [7:0] of);
    int w;
    int n;
    logic [64:0] mask;
    r = '0; cf = '0; of = '0;
    w = 8 << lm;
    n = 64 / w;
    mask = (65'd1 << w) - 65'd1;
    if (op == 3'd3) r = a & b;
    else if (op == 3'd4) r = a | b;
    else if (op == 3'd5) r = a ^ b;
    else if (op >= 3'd6) r = a;
    else begin
      for (int k = 0; k < n; k++) begin
        logic [64:0] la, lb, s, lane_r;
        logic sa, sb, sr, c, v;
        la = ({1'b0, a} >> (k * w)) & mask;
        lb = ({1'b0, b} >> (k * w)) & mask;
        if (op == 3'd1) lb = (~lb) & mask;
        s  = la + lb + ((op == 3'd1) ? 65'd1 : 65'd0);
        c  = s[w];
        sa = la[w-1]; sb = lb[w-1]; sr = s[w-1];
        v  = (sa == sb) && (sr != sa);
        lane_r = s & mask;
        if (op == 3'd2 && v) lane_r = sa ? (65'd1 << (w - 1)) : (mask >> 1);
        r = r | lane_r[63:0] << (k * w);
        cf[k * (w / 8) + (w / 8) - 1] = c;
        of[k * (w / 8) + (w / 8) - 1] = v;
      end
    end
  endtask

  task automatic check_out(input string req, input logic [63:0] er,
                           input logic [7:0] ec, input logic [7:0] eo);
    n_vec++;
    if (!out_valid || out_result !== er || out_carry !== ec || out_ovf !== eo) begin
      n_bad++;
      $display("FAIL %s: got v=%0b r=%h c=%h o=%h, expected v=1 r=%h c=%h o=%h",
               req, out_valid, out_result, out_carry, out_ovf, er, ec, eo);
    end
  endtask

  // Offer one operation, let it be accepted, check at the next falling edge.
  task automatic run_one(input string req, input logic [2:0] op,
                         input logic [1:0] lm, input logic [63:0] a,
                         input logic [63:0] b);
    logic [63:0] er;
    logic [7:0]  ec, eo;
    ref_alu(op, lm, a, b, er, ec, eo);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_lane = lm; in_a = a; in_b = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req, er, ec, eo);
  endtask

  task automatic t_reset();
    n_vec++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R10: got out_valid=%0b in_ready=%0b, expected 0 1", out_valid, in_ready);
    end
  endtask

  task automatic t_add_modes();
    for (int m = 0; m < 4; m++) begin
      run_one("R1", 3'd0, m[1:0], 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
      run_one("R1", 3'd0, m[1:0], 64'h80FF_7FFF_FF00_01FF, 64'h8001_0001_0100_FF01);
      run_one("R4", 3'd0, m[1:0], 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101);
      for (int i = 0; i < 20; i++)
        run_one("R1", 3'd0, m[1:0], {$urandom, $urandom}, {$urandom, $urandom});
    end
  endtask

  task automatic t_sub_modes();
    for (int m = 0; m < 4; m++) begin
      run_one("R2", 3'd1, m[1:0], 64'h0, 64'h1);
      run_one("R2", 3'd1, m[1:0], 64'h0100_0000_8000_0001, 64'h0001_0001_0001_0001);
      run_one("R2", 3'd1, m[1:0], 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
      for (int i = 0; i < 20; i++)
        run_one("R2", 3'd1, m[1:0], {$urandom, $urandom}, {$urandom, $urandom});
    end
  endtask

  task automatic t_sat();
    for (int m = 0; m < 4; m++) begin
      run_one("R3", 3'd2, m[1:0], 64'h7F7F_7F7F_7F7F_7F7F, 64'h7F7F_7F7F_7F7F_7F7F);
      run_one("R3", 3'd2, m[1:0], 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080);
      run_one("R3", 3'd2, m[1:0], 64'h7FFF_8000_0000_7FFF, 64'h0001_FFFF_0000_0001);
      run_one("R3", 3'd2, m[1:0], 64'h0102_0304_F0F0_1010, 64'h0102_0304_0F0F_1010);
      for (int i = 0; i < 20; i++)
        run_one("R3", 3'd2, m[1:0], {$urandom, $urandom}, {$urandom, $urandom});
    end
  endtask

  task automatic t_logic();
    logic [63:0] a, b;
    a = {$urandom, $urandom};
    b = {$urandom, $urandom};
    for (int op = 3; op <= 5; op++)
      for (int m = 0; m < 4; m++)
        run_one("R5", op[2:0], m[1:0], a, b);
  endtask

  task automatic t_pass();
    for (int m = 0; m < 4; m++) begin
      run_one("R6", 3'd6, m[1:0], 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      run_one("R6", 3'd7, m[1:0], {$urandom, $urandom}, {$urandom, $urandom});
    end
  endtask

  task automatic t_backpressure();
    logic [63:0] r1, r2;
    logic [7:0]  c1, o1, c2, o2;
    ref_alu(3'd0, 2'd0, 64'h0102_0304_0506_07FF, 64'h0000_0000_0000_0001, r1, c1, o1);
    ref_alu(3'd1, 2'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, r2, c2, o2);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd0; in_lane = 2'd0;
    in_a = 64'h0102_0304_0506_07FF; in_b = 64'h1;
    @(negedge clk);
    in_op = 3'd1; in_lane = 2'd1; in_a = 64'h0; in_b = 64'h1;
    for (int i = 0; i < 3; i++) begin
      check_out("R8", r1, c1, o1);
      n_vec++;
      if (in_ready !== 1'b0) begin
        n_bad++;
        $display("FAIL R8: got in_ready=%0b, expected 0", in_ready);
      end
      @(negedge clk);
    end
    check_out("R8", r1, c1, o1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R7", r2, c2, o2);
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R7: got out_valid=%0b after drain, expected 0", out_valid);
    end
  endtask

  task automatic t_throughput();
    logic [63:0] va[8], vb[8], er[8];
    logic [2:0]  vo[8];
    logic [1:0]  vl[8];
    logic [7:0]  ec[8], eo[8];
    for (int i = 0; i < 8; i++) begin
      va[i] = {$urandom, $urandom}; vb[i] = {$urandom, $urandom};
      vo[i] = 3'(i % 6); vl[i] = 2'(i % 4);
      ref_alu(vo[i], vl[i], va[i], vb[i], er[i], ec[i], eo[i]);
    end
    out_ready = 1'b1;
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      if (i > 0) check_out("R9", er[i-1], ec[i-1], eo[i-1]);
      if (i < 8) begin
        n_vec++;
        if (in_ready !== 1'b1) begin
          n_bad++;
          $display("FAIL R9: got in_ready=%0b in streaming, expected 1", in_ready);
        end
        in_valid = 1'b1; in_op = vo[i]; in_lane = vl[i]; in_a = va[i]; in_b = vb[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: got no completion, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_modes();
    t_sub_modes();
    t_sat();
    t_logic();
    t_pass();
    t_backpressure();
    t_throughput();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule